// File: doc/BRIEF.md
# Latched Address Decoder with Mixed-Polarity Enables

This block turns a small binary address into a set of active-low select lines. At most one line is low at any time. With the default width, a 3-bit address drives eight lines. The line whose index equals the address goes low, so each line stands for one minterm of the address bits. Address bit 0 is the least significant.

A hold register sits in front of the decode logic and is controlled by a `freeze` input.

- While `freeze` is low, the decoder tracks the live address in the same cycle. The register also reloads on every clock edge.
- Once `freeze` is high, the register stops loading. The decoder then uses the address taken at the last clock edge before `freeze` rose, and ignores later address changes.

Two enables gate every output: `en_hi`, which is active high, and `en_lo_n`, which is active low. Their gating is combinational and never touches the held address.

A typical use is a chip-select decoder where the address must stay stable while the bus moves on.

Top module: `latched_sel_decoder`

## Requirements
- R1: A synchronous reset clears the held address to 0. If `freeze` is high at the first cycle after reset and the outputs are enabled, line 0 is low whatever the live address is.
- R2: When enabled with selected address N, line N of `sel_n` is 0 and every other line is 1. Address bit 0 is the least significant, so `sel_n` equals the all-ones vector with bit N cleared.
- R3: The outputs are enabled only when `en_hi` is 1 and `en_lo_n` is 0. For the other three enable combinations, every line of `sel_n` is 1.
- R4: While `freeze` is low, the selected address is the live `addr_in` in the same cycle, with no clock delay.
- R5: While `freeze` is high, the selected address is the value of `addr_in` sampled at the last rising clock edge at which `freeze` was low. Changes of `addr_in` while `freeze` stays high have no effect on `sel_n`.
- R6: Toggling `en_hi` or `en_lo_n` while `freeze` is high does not alter the held address. It shows again unchanged once both enables are asserted.
- R7: `ADDR_W` must lie between 1 and 6. Any other value stops elaboration. The number of lines is 2 to the power `ADDR_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | Live address |
| freeze | input | 1 | 0: transparent and reloading; 1: hold the sampled address |
| en_hi | input | 1 | Output enable, active high |
| en_lo_n | input | 1 | Output enable, active low |
| sel_n | output | 2**ADDR_W | Active-low one-hot select lines |

## Verification
Two functions can act in the same cycle:

- **Freeze onset.** In the cycle where `freeze` rises, the bench also moves the address to a new value. The output must show the address sampled at the previous edge, not the new live one.
- **Enable gating while frozen.** The enables are toggled while the address is frozen. The gating must force all lines high during the toggles, and the held value must survive them.

A behavioural model in the bench predicts `sel_n` every cycle. The bench sweeps all addresses under all eight settings of `freeze` and the two enables.

// File: rtl/latdec_pkg.sv
package latdec_pkg;
   localparam int unsigned DEF_ADDR_W = 3;
   localparam int unsigned MAX_ADDR_W = 6;

   function automatic int unsigned lines_for(input int unsigned aw);
      return 32'd1 << aw;
   endfunction
endpackage

// File: rtl/latdec_hold.sv
module latdec_hold #(
   parameter int unsigned ADDR_W = latdec_pkg::DEF_ADDR_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              freeze,
   output logic [ADDR_W-1:0] addr_sel
);
   logic [ADDR_W-1:0] held_q;

   always_ff @(posedge clk) begin
      if (rst)
         held_q <= '0;
      else if (!freeze)
         held_q <= addr_in;
   end

   assign addr_sel = freeze ? held_q : addr_in;

   // R5: a frozen edge never changes the stored address
   assert_hold_stable_R5: assert property (@(posedge clk) disable iff (rst)
      freeze |=> $stable(held_q));

   // R1: reset leaves the stored address at zero
   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (held_q == '0));
endmodule

// File: rtl/latdec_minterm.sv
module latdec_minterm #(
   parameter int unsigned ADDR_W = latdec_pkg::DEF_ADDR_W,
   localparam int unsigned LINES = latdec_pkg::lines_for(ADDR_W)
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [LINES-1:0]  hot
);
   for (genvar m = 0; m < LINES; m++) begin : g_term
      localparam logic [ADDR_W-1:0] CODE = m[ADDR_W-1:0];
      assign hot[m] = (addr == CODE);
   end
endmodule

// File: rtl/latdec_gate.sv
module latdec_gate #(
   parameter int unsigned LINES = 8
) (
   input  logic [LINES-1:0] hot,
   input  logic             en_hi,
   input  logic             en_lo_n,
   output logic [LINES-1:0] sel_n
);
   logic open_w;

   assign open_w = en_hi & ~en_lo_n;
   assign sel_n  = open_w ? ~hot : {LINES{1'b1}};
endmodule

// File: rtl/latched_sel_decoder.sv
module latched_sel_decoder #(
   parameter int unsigned ADDR_W = latdec_pkg::DEF_ADDR_W,
   localparam int unsigned LINES = latdec_pkg::lines_for(ADDR_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              freeze,
   input  logic              en_hi,
   input  logic              en_lo_n,
   output logic [LINES-1:0]  sel_n
);
   if (ADDR_W < 1 || ADDR_W > latdec_pkg::MAX_ADDR_W) begin : g_bad_width
      $error("latched_sel_decoder: ADDR_W out of range (R7)");
   end

   logic [ADDR_W-1:0] addr_sel;
   logic [LINES-1:0]  hot;

   latdec_hold #(.ADDR_W(ADDR_W)) u_hold (
      .clk     (clk),
      .rst     (rst),
      .addr_in (addr_in),
      .freeze  (freeze),
      .addr_sel(addr_sel)
   );

   latdec_minterm #(.ADDR_W(ADDR_W)) u_dec (
      .addr(addr_sel),
      .hot (hot)
   );

   latdec_gate #(.LINES(LINES)) u_gate (
      .hot    (hot),
      .en_hi  (en_hi),
      .en_lo_n(en_lo_n),
      .sel_n  (sel_n)
   );

   // R3: a closed enable pair forces every line high
   assert_gated_off_R3: assert property (@(posedge clk) disable iff (rst)
      !(en_hi && !en_lo_n) |-> (&sel_n));

   // R2: an open enable pair gives exactly one low line
   assert_single_low_R2: assert property (@(posedge clk) disable iff (rst)
      (en_hi && !en_lo_n) |-> ($countones(~sel_n) == 1));

   // R4: when transparent, the low line follows the live address
   assert_transparent_R4: assert property (@(posedge clk) disable iff (rst)
      (!freeze && en_hi && !en_lo_n) |-> (sel_n[addr_in] == 1'b0));
endmodule

// File: tb/test_latched_sel_decoder.sv
`timescale 1ns/1ps
module test_latched_sel_decoder;
   localparam int AW = 3;
   localparam int NL = 1 << AW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] addr_in = '0;
   logic          freeze = 1'b0;
   logic          en_hi = 1'b0;
   logic          en_lo_n = 1'b1;
   logic [NL-1:0] sel_n;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;
   int  model_held = 0;

   always #10 clk = ~clk;

   latched_sel_decoder #(.ADDR_W(AW)) i_latched_sel_decoder (
      .clk(clk), .rst(rst), .addr_in(addr_in), .freeze(freeze),
      .en_hi(en_hi), .en_lo_n(en_lo_n), .sel_n(sel_n)
   );

   // behavioural reference of the hold register
   always @(posedge clk) begin
      if (rst) model_held <= 0;
      else if (!freeze) model_held <= int'(addr_in);
   end

   function automatic logic [NL-1:0] expect_out(input int a, input bit on);
      logic [NL-1:0] v;
      v = '1;
      if (on) v[a] = 1'b0;
      return v;
   endfunction

   task automatic compare(input string tag);
      int a;
      bit on;
      logic [NL-1:0] e;
      a  = freeze ? model_held : int'(addr_in);
      on = en_hi && !en_lo_n;
      e  = expect_out(a, on);
      checks++;
      if (sel_n !== e) begin
         errors++;
         $display("FAIL %s: sel_n=%b expected=%b", tag, sel_n, e);
      end
   endtask

   task automatic drive(input int a, input bit f, input bit eh, input bit el);
      @(negedge clk);
      addr_in = a[AW-1:0];
      freeze  = f;
      en_hi   = eh;
      en_lo_n = el;
      #5;
   endtask

   function automatic string tag_of();
      if (!(en_hi && !en_lo_n)) return "R3";
      if (freeze) return "R5";
      return "R4/R2";
   endfunction

   initial begin
      rst = 1'b1; addr_in = 3'd6; freeze = 1'b0;
      repeat (3) @(posedge clk);
      // R1: held address cleared, line 0 selected while frozen
      drive(3, 1, 1, 0);
      rst = 1'b0;
      #1;
      compare("R1");
      checks++;
      if (sel_n !== 8'hFE) begin
         errors++;
         $display("FAIL R1: sel_n=%b expected=%b", sel_n, 8'hFE);
      end

      // sweep every address under every control combination
      for (int a = 0; a < NL; a++) begin
         for (int c = 0; c < 8; c++) begin
            drive(a, c[0], c[1], c[2]);
            compare(tag_of());
         end
      end

      // R2: explicit one-hot-low check for each address, transparent
      for (int a = 0; a < NL; a++) begin
         drive(a, 0, 1, 0);
         compare("R2");
      end

      // R5: freeze rises in the same cycle the address moves
      drive(5, 0, 1, 0);
      compare("R4");
      drive(2, 1, 1, 0);
      compare("R5");
      checks++;
      if (sel_n !== 8'hDF) begin
         errors++;
         $display("FAIL R5: sel_n=%b expected=%b", sel_n, 8'hDF);
      end
      for (int a = 0; a < NL; a++) begin
         drive(a, 1, 1, 0);
         compare("R5");
      end

      // R6: enables toggle while frozen, held value must survive
      drive(7, 1, 0, 0); compare("R6");
      drive(1, 1, 1, 1); compare("R6");
      drive(4, 1, 0, 1); compare("R6");
      drive(0, 1, 1, 0); compare("R6");
      checks++;
      if (sel_n !== 8'hDF) begin
         errors++;
         $display("FAIL R6: sel_n=%b expected=%b", sel_n, 8'hDF);
      end

      // release freeze: back to the live address at once
      drive(3, 0, 1, 0); compare("R4");
      drive(6, 0, 1, 0); compare("R4");
      drive(1, 1, 1, 0); compare("R5");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, got hang expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule